// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetcher

This block walks a circular list of transmit descriptors kept in a word-addressed memory. For each descriptor it reads the buffer it points to and sends that buffer as a stream of bytes on a valid/ready byte interface. When a buffer has been consumed, the block writes a completion status back into the descriptor's control word. Each descriptor takes two consecutive words. The word at the even offset holds the buffer's word address, and the word after it holds the control word. Descriptor `i` sits at `ring_base_i + 2*i`.

Software fills descriptors with the ownership bit clear and pulses `start_i`. The fetcher then processes descriptors in order until it finds one that software still owns. A halt request makes the fetcher stop at the next frame boundary. Frame timing, checksum insertion and collision handling belong to the consumer of the byte stream. The only thing the fetcher passes downstream about them is a per-buffer flag that says the frame must not get a checksum.

Top module: `txr_fetch`

## Requirements
- R1: After reset `busy_o`, `tx_valid_o`, `mem_rd_o` and `mem_wr_o` are low, and the ring position is descriptor 0. While idle, the block makes no memory access and presents no byte.
- R2: The control word at `ring_base_i + 2*i + 1` gives the byte length in bits 10:0. The buffer word address is at `ring_base_i + 2*i`. Byte k of a buffer is taken from word `buffer + k/4`, bits `8*(k%4)+7 : 8*(k%4)`, and bytes go out in increasing k.
- R3: A `start_i` pulse while idle starts the walk at the current ring position. `busy_o` is high from the next cycle until the block is idle again.
- R4: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_data_o`, `tx_last_o` and `tx_nocrc_o` hold their values. Exactly `length` bytes are sent per buffer.
- R5: `tx_last_o` is high only with the final byte of a buffer whose control bit 15 (end of frame) is set. `tx_nocrc_o` equals control bit 16 on every byte of that buffer.
- R6: Once a buffer is consumed, its control word is written back with bit 31 set and bits 29, 28 and 27 cleared. Every other bit is kept.
- R7: After a descriptor whose control bit 30 is set, the next descriptor is descriptor 0. Otherwise it is the following descriptor.
- R8: A descriptor read with bit 31 set while no frame is open sends the block idle and leaves that descriptor untouched. The ring position stays there, so the next start resumes at it.
- R9: A descriptor read with bit 31 set while a frame is open (the previous buffer lacked bit 15) makes the block rewrite the previous control word with bits 27 and 31 set. The block then goes idle.
- R10: A `halt_i` pulse while busy lets the open frame finish. The block stops after that frame's end-of-frame write-back, and this includes a halt that arrives in the write-back cycle itself. A halt while idle has no effect.
- R11: At most one memory access happens per cycle. Read data is taken in the cycle after `mem_rd_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle start command |
| halt_i | input | 1 | One-cycle halt request |
| ring_base_i | input | AW | Word address of descriptor 0 |
| busy_o | output | 1 | High while the ring is being walked |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, one cycle after the strobe |
| tx_valid_o | output | 1 | Byte valid |
| tx_data_o | output | 8 | Byte data |
| tx_last_o | output | 1 | Final byte of a frame |
| tx_nocrc_o | output | 1 | Frame must be sent without checksum |
| tx_ready_i | input | 1 | Consumer accepts the byte |

## Verification
A halt request and the end-of-frame write-back can fall in the same cycle. This is the case most likely to be lost, because the pending-halt register has not yet captured the request. The bench provokes it by watching for the write strobe on a falling edge and raising `halt_i` for exactly that clock. It judges the result by the stream, which must hold only the first frame, and by the second frame's control word, which must still be unchanged in memory once `busy_o` drops. A later start must then send that second frame. Lengths from 1 to 9 bytes are swept across every byte-lane alignment and several ready patterns, and the ring is wrapped more than once.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int LEN_W   = 11;
  localparam int EOF_B   = 15;
  localparam int NOCRC_B = 16;
  localparam int EXH_B   = 27;
  localparam int UNDR_B  = 28;
  localparam int RTRY_B  = 29;
  localparam int WRAP_B  = 30;
  localparam int OWN_B   = 31;

  typedef enum logic [3:0] {
    S_IDLE, S_CTL_RD, S_CTL_CHK, S_ADR_RD, S_ADR_CHK,
    S_WRD_RD, S_WRD_LD, S_SEND, S_WB, S_EXH
  } fsm_t;

  // Completion image of a control word: owned back by software, error
  // flags cleared (no underrun can occur with a back-pressured stream).
  function automatic logic [31:0] done_word(input logic [31:0] c);
    logic [31:0] w;
    w         = c;
    w[OWN_B]  = 1'b1;
    w[RTRY_B] = 1'b0;
    w[UNDR_B] = 1'b0;
    w[EXH_B]  = 1'b0;
    return w;
  endfunction
endpackage

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr #(
  parameter int AW = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base_i,
  input  logic          adv_i,
  input  logic          wrap_i,
  output logic [AW-1:0] desc_addr_o,
  output logic [AW-1:0] ctl_addr_o,
  output logic [AW-1:0] prev_ctl_addr_o
);
  localparam int OW = IW + 1;

  logic [IW-1:0] idx_q, idx_d, prev_q;

  always_comb begin
    idx_d = wrap_i ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      prev_q <= '0;
    end else if (adv_i) begin
      idx_q  <= idx_d;
      prev_q <= idx_q;
    end
  end

  logic [OW-1:0] off_cur, off_prev;
  assign off_cur         = {idx_q, 1'b0};
  assign off_prev        = {prev_q, 1'b1};
  assign desc_addr_o     = base_i + AW'(off_cur);
  assign ctl_addr_o      = desc_addr_o + 1'b1;
  assign prev_ctl_addr_o = base_i + AW'(off_prev);

  AST_WRAP_TO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i && wrap_i && $stable(base_i) |=> desc_addr_o == base_i) else $error("wrap"); // R7
endmodule

// File: rtl/txr_byte_lane.sv
module txr_byte_lane #(
  parameter int AW = 16,
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          buf_ld_i,
  input  logic [AW-1:0] buf_addr_i,
  input  logic          word_ld_i,
  input  logic [31:0]   word_i,
  input  logic          step_i,
  input  logic [LW-1:0] len_i,
  output logic [AW-1:0] rd_addr_o,
  output logic [7:0]    byte_o,
  output logic          final_o,
  output logic          lane_end_o
);
  localparam int WW = LW - 2;

  logic [AW-1:0] buf_q;
  logic [31:0]   word_q;
  logic [LW-1:0] cnt_q;
  logic [WW-1:0] wofs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      word_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (buf_ld_i) begin
        buf_q <= buf_addr_i;
        cnt_q <= '0;
      end else if (step_i) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (word_ld_i) word_q <= word_i;
    end
  end

  assign wofs       = cnt_q[LW-1:2];
  assign rd_addr_o  = buf_q + AW'(wofs);
  assign byte_o     = word_q[{cnt_q[1:0], 3'b000} +: 8];
  assign final_o    = (cnt_q == len_i - 1'b1);
  assign lane_end_o = (cnt_q[1:0] == 2'b11);

  AST_STEP_BEFORE_END: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> !final_o) else $error("step past end"); // R4
endmodule

// File: rtl/txr_fetch.sv
module txr_fetch #(
  parameter int AW = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          halt_i,
  input  logic [AW-1:0] ring_base_i,
  output logic          busy_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  output logic          tx_valid_o,
  output logic [7:0]    tx_data_o,
  output logic          tx_last_o,
  output logic          tx_nocrc_o,
  input  logic          tx_ready_i
);
  import txr_pkg::*;

  // Asynchronous assertion, synchronous release.
  logic [1:0] rsync_q;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q = rsync_q[1];

  fsm_t        state_q, state_d;
  logic [31:0] ctrl_q, wb_q;
  logic        in_frame_q, in_frame_d, frm_en;
  logic        halt_q, halt_d;
  logic        ctl_en, wb_en;

  logic          adv, buf_ld, word_ld, step;
  logic [AW-1:0] desc_addr, ctl_addr, prev_ctl_addr, lane_addr;
  logic [7:0]    lane_byte;
  logic          lane_final, lane_end;
  logic          eof_bit;

  assign eof_bit = ctrl_q[EOF_B];

  txr_ring_ptr #(.AW(AW), .IW(IW)) u_ptr (
    .clk(clk), .rst_n(rst_q), .base_i(ring_base_i), .adv_i(adv),
    .wrap_i(ctrl_q[WRAP_B]), .desc_addr_o(desc_addr), .ctl_addr_o(ctl_addr),
    .prev_ctl_addr_o(prev_ctl_addr)
  );

  txr_byte_lane #(.AW(AW), .LW(LEN_W)) u_lane (
    .clk(clk), .rst_n(rst_q), .buf_ld_i(buf_ld), .buf_addr_i(mem_rdata_i[AW-1:0]),
    .word_ld_i(word_ld), .word_i(mem_rdata_i), .step_i(step),
    .len_i(ctrl_q[LEN_W-1:0]), .rd_addr_o(lane_addr), .byte_o(lane_byte),
    .final_o(lane_final), .lane_end_o(lane_end)
  );

  // Next-state and output decode
  always_comb begin
    state_d     = state_q;
    mem_rd_o    = 1'b0;
    mem_wr_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    buf_ld      = 1'b0;
    word_ld     = 1'b0;
    step        = 1'b0;
    adv         = 1'b0;
    ctl_en      = 1'b0;
    wb_en       = 1'b0;
    frm_en      = 1'b0;
    in_frame_d  = in_frame_q;
    unique case (state_q)
      S_IDLE: begin
        if (start_i) state_d = S_CTL_RD;
      end
      S_CTL_RD: begin
        mem_rd_o   = 1'b1;
        mem_addr_o = ctl_addr;
        state_d    = S_CTL_CHK;
      end
      S_CTL_CHK: begin
        if (mem_rdata_i[OWN_B]) begin
          state_d = in_frame_q ? S_EXH : S_IDLE;
        end else begin
          ctl_en  = 1'b1;
          state_d = S_ADR_RD;
        end
      end
      S_ADR_RD: begin
        mem_rd_o   = 1'b1;
        mem_addr_o = desc_addr;
        state_d    = S_ADR_CHK;
      end
      S_ADR_CHK: begin
        buf_ld  = 1'b1;
        state_d = (ctrl_q[LEN_W-1:0] == '0) ? S_WB : S_WRD_RD;
      end
      S_WRD_RD: begin
        mem_rd_o   = 1'b1;
        mem_addr_o = lane_addr;
        state_d    = S_WRD_LD;
      end
      S_WRD_LD: begin
        word_ld = 1'b1;
        state_d = S_SEND;
      end
      S_SEND: begin
        if (tx_ready_i) begin
          if (lane_final) begin
            state_d = S_WB;
          end else begin
            step = 1'b1;
            if (lane_end) state_d = S_WRD_RD;
          end
        end
      end
      S_WB: begin
        mem_wr_o    = 1'b1;
        mem_addr_o  = ctl_addr;
        mem_wdata_o = done_word(ctrl_q);
        adv         = 1'b1;
        wb_en       = 1'b1;
        frm_en      = 1'b1;
        in_frame_d  = !eof_bit;
        state_d     = (eof_bit && (halt_q || halt_i)) ? S_IDLE : S_CTL_RD;
      end
      S_EXH: begin
        mem_wr_o           = 1'b1;
        mem_addr_o         = prev_ctl_addr;
        mem_wdata_o        = wb_q;
        mem_wdata_o[EXH_B] = 1'b1;
        frm_en             = 1'b1;
        in_frame_d         = 1'b0;
        state_d            = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_comb begin
    if (state_q == S_IDLE || state_d == S_IDLE) halt_d = 1'b0;
    else                                        halt_d = halt_q | halt_i;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state_q    <= S_IDLE;
      ctrl_q     <= '0;
      wb_q       <= '0;
      in_frame_q <= 1'b0;
      halt_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      halt_q  <= halt_d;
      if (ctl_en) ctrl_q     <= mem_rdata_i;
      if (wb_en)  wb_q       <= done_word(ctrl_q);
      if (frm_en) in_frame_q <= in_frame_d;
    end
  end

  assign busy_o     = (state_q != S_IDLE);
  assign tx_valid_o = (state_q == S_SEND);
  assign tx_data_o  = lane_byte;
  assign tx_last_o  = tx_valid_o && lane_final && eof_bit;
  assign tx_nocrc_o = tx_valid_o && ctrl_q[NOCRC_B];

  AST_ONE_MEM_OP: assert property (@(posedge clk) disable iff (!rst_q)
    !(mem_rd_o && mem_wr_o)) else $error("rd and wr"); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_q)
    !busy_o |-> !mem_rd_o && !mem_wr_o && !tx_valid_o) else $error("idle activity"); // R1
  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_q)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o)
      && $stable(tx_nocrc_o)) else $error("stream changed"); // R4
  AST_WB_OWNED: assert property (@(posedge clk) disable iff (!rst_q)
    mem_wr_o |-> mem_wdata_o[OWN_B] && !mem_wdata_o[RTRY_B] && !mem_wdata_o[UNDR_B])
    else $error("write-back image"); // R6
  AST_LAST_THEN_WB: assert property (@(posedge clk) disable iff (!rst_q)
    tx_valid_o && tx_ready_i && tx_last_o |=> mem_wr_o) else $error("no write-back"); // R5
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_q)
    !busy_o && start_i |=> busy_o) else $error("start ignored"); // R3
endmodule

// File: tb/test_txr_fetch.sv
`timescale 1ns/1ps
module test_txr_fetch;
  localparam int AW   = 16;
  localparam int BASE = 'h40;
  localparam int NDSC = 4;

  logic          clk = 1'b0;
  logic          rst_n, start, halt, tx_ready;
  logic [AW-1:0] ring_base;
  logic          busy, mem_rd, mem_wr, tx_valid, tx_last, tx_nocrc;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;
  logic [7:0]    tx_data;

  always #2 clk = ~clk;

  txr_fetch #(.AW(AW), .IW(4)) i_txr_fetch (
    .clk(clk), .rst_n(rst_n), .start_i(start), .halt_i(halt), .ring_base_i(ring_base),
    .busy_o(busy), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .tx_valid_o(tx_valid),
    .tx_data_o(tx_data), .tx_last_o(tx_last), .tx_nocrc_o(tx_nocrc), .tx_ready_i(tx_ready)
  );

  int checks = 0;
  int errors = 0;
  int both_ops = 0;
  int cyc = 0;
  int rmode = 0;
  int bidx = 0;
  logic [31:0] mem [0:255];
  logic [9:0]  exp_q [$];

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Ready pattern and byte monitor, evaluated between clock edges.
  always @(negedge clk) begin
    cyc++;
    tx_ready = (rmode == 0) ? 1'b1 : ((cyc % rmode) != 0);
    if (mem_rd && mem_wr) both_ops++;
    if (tx_valid && tx_ready) begin
      if (exp_q.size() == 0) begin
        chk(0, "R4", "unexpected byte", tx_data, 0);
      end else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        chk(tx_data == e[7:0], "R2", "byte value", tx_data, e[7:0]);
        chk({tx_nocrc, tx_last} == e[9:8], "R5", "nocrc/last flags",
            {tx_nocrc, tx_last}, e[9:8]);
      end
    end
  end

  function automatic int nxt(input int i);
    return (i == NDSC - 1) ? 0 : i + 1;
  endfunction

  function automatic logic [7:0] pat(input int w, input int k);
    return 8'(((w * 4 + k) * 7) + 3);
  endfunction

  function automatic logic [31:0] mk(input int len, input bit eof, input bit nocrc,
                                     input bit own, input int idx, input logic [31:0] extra);
    logic [31:0] c;
    c = extra | 32'(len);
    c[15] = eof;
    c[16] = nocrc;
    c[31] = own;
    c[30] = (idx == NDSC - 1);
    return c;
  endfunction

  function automatic logic [31:0] done(input logic [31:0] c);
    return (c | 32'h8000_0000) & ~32'h3800_0000;
  endfunction

  task automatic set_desc(input int idx, input int bufw, input logic [31:0] c);
    mem[BASE + 2 * idx]     = 32'(bufw);
    mem[BASE + 2 * idx + 1] = c;
  endtask

  function automatic logic [31:0] ctl_of(input int idx);
    return mem[BASE + 2 * idx + 1];
  endfunction

  task automatic push_buf(input int bufw, input int len, input bit eof, input bit nocrc);
    for (int k = 0; k < len; k++) begin
      logic [7:0] b;
      b = pat(bufw + k / 4, k % 4);
      exp_q.push_back({nocrc, eof && (k == len - 1), b});
    end
  endtask

  task automatic wait_idle(input string req);
    int n;
    n = 0;
    while (busy && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(!busy, req, "returns idle", busy, 0);
    chk(exp_q.size() == 0, req, "bytes missing", exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R3", "busy after start", busy, 1);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int a, b, s;
    logic [31:0] ca, cb, cs;
    for (int w = 0; w < 256; w++)
      mem[w] = {pat(w, 3), pat(w, 2), pat(w, 1), pat(w, 0)};
    rst_n = 1'b0; start = 1'b0; halt = 1'b0; ring_base = AW'(BASE);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !tx_valid && !mem_rd && !mem_wr, "R1", "reset outputs",
        {busy, tx_valid, mem_rd, mem_wr}, 0);

    // Sweep lengths 1..9, every lane alignment, three ready patterns, ring wraps (R7, R8)
    for (int len = 1; len <= 9; len++) begin
      logic [31:0] extra;
      a = bidx; b = nxt(bidx);
      rmode = len % 3 == 0 ? 0 : (len % 3 == 1 ? 3 : 2);
      extra = 32'h0010_0000;
      if (len % 3 == 0) extra[28] = 1'b1;
      if (len % 4 == 0) extra[27] = 1'b1;
      ca = mk(len, 1, len[0], 0, a, extra);
      cb = mk(0, 1, 0, 1, b, 0);
      set_desc(a, 'h80 + len * 3, ca);
      set_desc(b, 0, cb);
      push_buf('h80 + len * 3, len, 1, len[0]);
      pulse_start();
      wait_idle("R4");
      chk(ctl_of(a) == done(ca), "R6", "write-back word", ctl_of(a), done(ca));
      chk(ctl_of(b) == cb, "R8", "owned descriptor untouched", ctl_of(b), cb);
      bidx = b;
    end

    // Two-buffer frame: last only at frame end (R5), ring advance (R7)
    rmode = 2;
    a = bidx; b = nxt(a); s = nxt(b);
    ca = mk(5, 0, 1, 0, a, 0); cb = mk(3, 1, 0, 0, b, 0); cs = mk(0, 0, 0, 1, s, 0);
    set_desc(a, 'hA0, ca); set_desc(b, 'hB1, cb); set_desc(s, 0, cs);
    push_buf('hA0, 5, 0, 1); push_buf('hB1, 3, 1, 0);
    pulse_start();
    wait_idle("R5");
    chk(ctl_of(a) == done(ca), "R6", "first buffer write-back", ctl_of(a), done(ca));
    chk(ctl_of(b) == done(cb), "R7", "second buffer write-back", ctl_of(b), done(cb));
    bidx = s;

    // Buffers exhausted mid-frame (R9)
    rmode = 0;
    a = bidx; b = nxt(a);
    ca = mk(3, 0, 0, 0, a, 32'h0000_4000); cb = mk(2, 1, 0, 1, b, 0);
    set_desc(a, 'hC0, ca); set_desc(b, 'hC8, cb);
    push_buf('hC0, 3, 0, 0);
    pulse_start();
    wait_idle("R9");
    chk(ctl_of(a) == (done(ca) | 32'h0800_0000), "R9", "exhausted flag", ctl_of(a),
        done(ca) | 32'h0800_0000);
    chk(ctl_of(b) == cb, "R9", "owned descriptor untouched", ctl_of(b), cb);
    bidx = b;

    // Halt during a frame: frame completes, next frame waits (R10)
    rmode = 3;
    a = bidx; b = nxt(a); s = nxt(b);
    ca = mk(6, 1, 0, 0, a, 0); cb = mk(4, 1, 1, 0, b, 0); cs = mk(0, 0, 0, 1, s, 0);
    set_desc(a, 'hD0, ca); set_desc(b, 'hD4, cb); set_desc(s, 0, cs);
    push_buf('hD0, 6, 1, 0);
    pulse_start();
    while (!tx_valid) @(negedge clk);
    halt = 1'b1;
    @(negedge clk);
    halt = 1'b0;
    wait_idle("R10");
    chk(ctl_of(a) == done(ca), "R10", "halted frame written back", ctl_of(a), done(ca));
    chk(ctl_of(b) == cb, "R10", "next frame held after halt", ctl_of(b), cb);
    push_buf('hD4, 4, 1, 1);
    pulse_start();
    wait_idle("R10");
    chk(ctl_of(b) == done(cb), "R3", "resume after halt", ctl_of(b), done(cb));
    bidx = s;

    // Halt in the very write-back cycle of the frame (R10)
    rmode = 0;
    a = bidx; b = nxt(a); s = nxt(b);
    ca = mk(2, 1, 0, 0, a, 0); cb = mk(3, 1, 0, 0, b, 0); cs = mk(0, 0, 0, 1, s, 0);
    set_desc(a, 'hE0, ca); set_desc(b, 'hE2, cb); set_desc(s, 0, cs);
    push_buf('hE0, 2, 1, 0);
    pulse_start();
    while (!mem_wr) @(negedge clk);
    halt = 1'b1;
    @(negedge clk);
    halt = 1'b0;
    wait_idle("R10");
    chk(ctl_of(b) == cb, "R10", "same-cycle halt honoured", ctl_of(b), cb);
    push_buf('hE2, 3, 1, 0);
    pulse_start();
    wait_idle("R10");
    bidx = s;

    // Halt while idle has no effect (R10)
    a = bidx; b = nxt(a); s = nxt(b);
    ca = mk(1, 1, 0, 0, a, 0); cb = mk(2, 1, 0, 0, b, 0); cs = mk(0, 0, 0, 1, s, 0);
    set_desc(a, 'hF0, ca); set_desc(b, 'hF4, cb); set_desc(s, 0, cs);
    @(negedge clk); halt = 1'b1; @(negedge clk); halt = 1'b0;
    chk(!busy && !mem_rd && !mem_wr, "R1", "idle stays quiet", busy, 0);
    push_buf('hF0, 1, 1, 0); push_buf('hF4, 2, 1, 0);
    pulse_start();
    wait_idle("R10");
    chk(ctl_of(b) == done(cb), "R10", "idle halt ignored", ctl_of(b), done(cb));

    chk(both_ops == 0, "R11", "simultaneous read and write", both_ops, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule